// File: doc/BRIEF.md
# Burst-of-Two Split-Port SRAM Core

This block is a synthesizable model of a quad-data-rate style static memory. It has a read data port and a write data port of its own, and both share one address bus. Every access moves a burst of two words. The burst address is the external address with one extra low bit appended: the first word goes to offset 0 and the second to offset 1. One clock stands in for a clock pair. Its rising edge acts as the primary edge and its falling edge as the complementary edge. Read and write sequencing run side by side, so a new read and a new write may both start on every rising edge.

A write finishes half a cycle after it starts. Its address and its second data beat are taken on the falling edge, and the finished burst is parked in a write register. That register is copied into the array only when the next write finishes. A read of the parked address merges the register over the array, one byte lane at a time, so readers always see the newest data. The read port has no back-pressure. While `rvalid` is high, the consumer must take the first word during the high phase of the clock and the second word during the low phase. When no read data is due, the output is released: `rvalid` is low and `rdata` is zero, which stands in for a floating bus.

Top module: `qbs_burst_sram`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `rvalid` is low and `rdata` is zero. No write is pending.
- R2: When `rd_sel_n` is low at a rising edge, `addr` is captured at that edge. From the next rising edge `rvalid` is high for one full cycle. `rdata` carries word 2A+0 in the high phase and word 2A+1 in the following low phase.
- R3: Burst order is fixed. The first beat of a write lands in word 2A+0 and the second beat in word 2A+1, where A is the write address.
- R4: When `wr_sel_n` is low at a rising edge, a write starts. `wdata` and `lane_wr_n` at that rising edge form beat 0. `addr`, `wdata` and `lane_wr_n` at the following falling edge give the write address and beat 1.
- R5: `lane_wr_n[0]` low enables writing of bits 8:0 and `lane_wr_n[1]` low enables bits 17:9. The mask is sampled separately for each beat. A lane whose bit is high keeps its old contents.
- R6: A read sees every write that started on or before the rising edge that issued the read, including a write started on that same edge to the same address. Lanes are merged per beat.
- R7: The ports are independent. A read and a write may start on the same edge. Reads on consecutive edges give unbroken valid output.
- R8: In any cycle that does not deliver read data, `rvalid` is low and `rdata` is zero.
- R9: `addr`, `wdata` and `lane_wr_n` have no effect when they are presented on edges where no transaction samples them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge is the primary edge, falling edge the complementary edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_sel_n | input | 1 | Active-low read start, sampled on the rising edge |
| wr_sel_n | input | 1 | Active-low write start, sampled on the rising edge |
| addr | input | ADDR_W | Shared address: read address on the rising edge, write address on the falling edge |
| wdata | input | DATA_W | Write data: beat 0 on the rising edge, beat 1 on the falling edge |
| lane_wr_n | input | LANES | Active-low byte-lane write enables, one set per beat |
| rdata | output | DATA_W | Read data: first word in the high phase, second word in the low phase, zero when idle |
| rvalid | output | 1 | High for each cycle that carries a read burst |

## Verification
The bench fills every address and then sweeps all sixteen pairs of per-beat lane masks over every address. Each write is read back on the next edge, so every result comes through the forwarding path. A design that merged by whole word, or that used one mask for both beats, would return the wrong lanes. Reads issued on the same edge as a write to the same address catch a design that forwards only writes finished before the read edge; such a design would return stale array data. Idle steps drive junk address, data and all-enabled masks. Concurrent read-write runs and back-to-back reads expose swapped burst offsets, a lost second beat, an output left driven after a burst, and stores from cycles that started no write.

// File: rtl/qbs_pkg.sv
`timescale 1ns/1ps
package qbs_pkg;
  // default configuration shared by the core and its sub-blocks
  localparam int unsigned QBS_ADDR_W = 4;
  localparam int unsigned QBS_DATA_W = 18;
  localparam int unsigned QBS_LANES  = 2;
  // every transaction is a burst of this many words
  localparam int unsigned QBS_BEATS  = 2;

  typedef enum logic {
    BEAT_FIRST  = 1'b0,
    BEAT_SECOND = 1'b1
  } qbs_beat_e;
endpackage

// File: rtl/qbs_read_port.sv
`timescale 1ns/1ps
module qbs_read_port
  import qbs_pkg::*;
#(
  parameter int unsigned ADDR_W = QBS_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_sel_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_pend,
  output logic [ADDR_W-1:0] rd_addr
);
  // read request and its address are both taken on the rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      rd_addr <= '0;
    end else begin
      rd_pend <= !rd_sel_n;
      if (!rd_sel_n) rd_addr <= addr;
    end
  end
endmodule

// File: rtl/qbs_write_port.sv
`timescale 1ns/1ps
module qbs_write_port
  import qbs_pkg::*;
#(
  parameter int unsigned ADDR_W = QBS_ADDR_W,
  parameter int unsigned DATA_W = QBS_DATA_W,
  parameter int unsigned LANES  = QBS_LANES
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_sel_n,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  input  logic [LANES-1:0]                  lane_wr_n,
  output logic                              reg_valid,
  output logic [ADDR_W-1:0]                 reg_addr,
  output logic [QBS_BEATS-1:0][DATA_W-1:0]  reg_d,
  output logic [QBS_BEATS-1:0][LANES-1:0]   reg_en,
  output logic                              commit_en
);
  logic              wpend;
  logic [DATA_W-1:0] b0_d;
  logic [LANES-1:0]  b0_en;

  // rising edge: start of write, first beat
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpend <= 1'b0;
      b0_d  <= '0;
      b0_en <= '0;
    end else begin
      wpend <= !wr_sel_n;
      if (!wr_sel_n) begin
        b0_d  <= wdata;
        b0_en <= ~lane_wr_n;
      end
    end
  end

  // falling edge: address and second beat complete the burst, which
  // replaces the parked one (the parked one is committed on this edge)
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_valid <= 1'b0;
      reg_addr  <= '0;
      reg_d     <= '0;
      reg_en    <= '0;
    end else if (wpend) begin
      reg_valid           <= 1'b1;
      reg_addr            <= addr;
      reg_d[BEAT_FIRST]   <= b0_d;
      reg_d[BEAT_SECOND]  <= wdata;
      reg_en[BEAT_FIRST]  <= b0_en;
      reg_en[BEAT_SECOND] <= ~lane_wr_n;
    end
  end

  // the array takes the parked burst on the edge a newer burst lands
  assign commit_en = wpend && reg_valid;
endmodule

// File: rtl/qbs_array.sv
`timescale 1ns/1ps
module qbs_array
  import qbs_pkg::*;
#(
  parameter int unsigned ADDR_W = QBS_ADDR_W,
  parameter int unsigned DATA_W = QBS_DATA_W,
  parameter int unsigned LANES  = QBS_LANES
) (
  input  logic                              clk,
  input  logic                              commit_en,
  input  logic [ADDR_W-1:0]                 cm_addr,
  input  logic [QBS_BEATS-1:0][DATA_W-1:0]  cm_d,
  input  logic [QBS_BEATS-1:0][LANES-1:0]   cm_en,
  input  logic [ADDR_W-1:0]                 rd_addr,
  output logic [QBS_BEATS-1:0][DATA_W-1:0]  rd_word
);
  localparam int unsigned LANE_W = DATA_W / LANES;
  localparam int unsigned WORDS  = QBS_BEATS << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] store [WORDS];

    always_ff @(negedge clk) begin
      if (commit_en) begin
        if (cm_en[BEAT_FIRST][l])
          store[{cm_addr, BEAT_FIRST}]  <= cm_d[BEAT_FIRST][l*LANE_W +: LANE_W];
        if (cm_en[BEAT_SECOND][l])
          store[{cm_addr, BEAT_SECOND}] <= cm_d[BEAT_SECOND][l*LANE_W +: LANE_W];
      end
    end

    for (genvar b = 0; b < QBS_BEATS; b++) begin : g_rd
      assign rd_word[b][l*LANE_W +: LANE_W] = store[{rd_addr, 1'(b)}];
    end
  end
endmodule

// File: rtl/qbs_out_stage.sv
`timescale 1ns/1ps
module qbs_out_stage
  import qbs_pkg::*;
#(
  parameter int unsigned ADDR_W = QBS_ADDR_W,
  parameter int unsigned DATA_W = QBS_DATA_W,
  parameter int unsigned LANES  = QBS_LANES
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              rd_pend,
  input  logic [ADDR_W-1:0]                 rd_addr,
  input  logic [QBS_BEATS-1:0][DATA_W-1:0]  arr_word,
  input  logic                              reg_valid,
  input  logic [ADDR_W-1:0]                 reg_addr,
  input  logic [QBS_BEATS-1:0][DATA_W-1:0]  reg_d,
  input  logic [QBS_BEATS-1:0][LANES-1:0]   reg_en,
  output logic [DATA_W-1:0]                 rdata,
  output logic                              rvalid
);
  localparam int unsigned LANE_W = DATA_W / LANES;

  logic                             hit;
  logic [QBS_BEATS-1:0][DATA_W-1:0] merged;
  logic [QBS_BEATS-1:0][DATA_W-1:0] q;

  assign hit = reg_valid && (reg_addr == rd_addr);

  // newest data wins lane by lane
  for (genvar b = 0; b < QBS_BEATS; b++) begin : g_beat
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign merged[b][l*LANE_W +: LANE_W] = (hit && reg_en[b][l])
        ? reg_d[b][l*LANE_W +: LANE_W]
        : arr_word[b][l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      q      <= '0;
    end else begin
      rvalid <= rd_pend;
      if (rd_pend) q <= merged;
    end
  end

  // double-rate output: high phase first word, low phase second word
  assign rdata = !rvalid ? '0 : (clk ? q[BEAT_FIRST] : q[BEAT_SECOND]);
endmodule

// File: rtl/qbs_burst_sram.sv
`timescale 1ns/1ps
module qbs_burst_sram
  import qbs_pkg::*;
#(
  parameter int unsigned ADDR_W = QBS_ADDR_W,
  parameter int unsigned DATA_W = QBS_DATA_W,
  parameter int unsigned LANES  = QBS_LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_sel_n,
  input  logic              wr_sel_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  lane_wr_n,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic                             rd_pend;
  logic [ADDR_W-1:0]                rd_addr;
  logic                             reg_valid;
  logic [ADDR_W-1:0]                reg_addr;
  logic [QBS_BEATS-1:0][DATA_W-1:0] reg_d;
  logic [QBS_BEATS-1:0][LANES-1:0]  reg_en;
  logic                             commit_en;
  logic [QBS_BEATS-1:0][DATA_W-1:0] arr_word;

  qbs_read_port #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .addr(addr),
    .rd_pend(rd_pend), .rd_addr(rd_addr)
  );

  qbs_write_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_sel_n(wr_sel_n), .addr(addr),
    .wdata(wdata), .lane_wr_n(lane_wr_n),
    .reg_valid(reg_valid), .reg_addr(reg_addr), .reg_d(reg_d),
    .reg_en(reg_en), .commit_en(commit_en)
  );

  qbs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_arr (
    .clk(clk), .commit_en(commit_en), .cm_addr(reg_addr), .cm_d(reg_d),
    .cm_en(reg_en), .rd_addr(rd_addr), .rd_word(arr_word)
  );

  qbs_out_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_out (
    .clk(clk), .rst_n(rst_n), .rd_pend(rd_pend), .rd_addr(rd_addr),
    .arr_word(arr_word), .reg_valid(reg_valid), .reg_addr(reg_addr),
    .reg_d(reg_d), .reg_en(reg_en), .rdata(rdata), .rvalid(rvalid)
  );
endmodule

// File: rtl/qbs_sram_checker.sv
`timescale 1ns/1ps
module qbs_sram_checker #(
  parameter int unsigned DW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_sel_n,
  input logic [DW-1:0] rdata,
  input logic          rvalid
);
  // R1: reset leaves the read port idle
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!rvalid && rdata == '0));

  // R2: a read request yields a valid burst one cycle later
  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel_n |-> ##2 rvalid);

  // R8: no request, no burst
  p_no_request_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel_n |-> ##2 !rvalid);

  // R8: output released whenever not valid
  p_released_when_idle_r8: assert property (@(negedge clk) disable iff (!rst_n)
    !rvalid |-> rdata == '0);
endmodule

bind qbs_burst_sram qbs_sram_checker #(.DW(DATA_W)) u_qbs_chk (
  .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .rdata(rdata), .rvalid(rvalid)
);

// File: tb/qbs_burst_sram_bench.sv
`timescale 1ns/1ps
module qbs_burst_sram_bench;
  localparam int AW = 4;
  localparam int DW = 18;
  localparam int NA = 1 << AW;
  localparam int NW = 2 * NA;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rd_sel_n = 1'b1;
  logic          wr_sel_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [1:0]    lane_wr_n = 2'b11;
  logic [DW-1:0] rdata;
  logic          rvalid;

  always #2.5 clk = ~clk;

  qbs_burst_sram u_qbs_burst_sram (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .addr(addr), .wdata(wdata), .lane_wr_n(lane_wr_n),
    .rdata(rdata), .rvalid(rvalid)
  );

  int            total = 0;
  int            bad = 0;
  bit            done = 0;
  bit            mon_en = 0;
  string         tag = "R1";
  logic [DW-1:0] mdl [NW];

  task automatic check(bit ok, string req, string what, logic [DW-1:0] ad,
                       logic av, logic [DW-1:0] ed, logic ev);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: rdata=%h rvalid=%b expected rdata=%h rvalid=%b",
               req, what, ad, av, ed, ev);
    end
  endtask

  // R5: lane 0 is bits 8:0, lane 1 is bits 17:9, enable active low
  function automatic logic [DW-1:0] mix(logic [DW-1:0] old, logic [DW-1:0] nw,
                                        logic [1:0] en_n);
    mix = old;
    if (!en_n[0]) mix[8:0]  = nw[8:0];
    if (!en_n[1]) mix[17:9] = nw[17:9];
  endfunction

  function automatic logic [DW-1:0] pat(int a, int b, int k);
    return DW'(a * 4099 + b * 2053 + k * 389 + 17);
  endfunction

  // one clock cycle of stimulus; entered and left just after a falling edge
  task automatic step(bit dr, int ra, bit dw, int wa,
                      logic [DW-1:0] d0, logic [DW-1:0] d1,
                      logic [1:0] m0, logic [1:0] m1);
    #0.75;
    rd_sel_n  = !dr;
    wr_sel_n  = !dw;
    addr      = dr ? AW'(ra) : AW'(ra + 9);      // R9 junk when unused
    wdata     = dw ? d0 : 18'h15a5a;
    lane_wr_n = dw ? m0 : 2'b00;
    @(posedge clk);
    #1.25;
    addr      = dw ? AW'(wa) : AW'(wa + 3);
    wdata     = dw ? d1 : 18'h0f0f0;
    lane_wr_n = dw ? m1 : 2'b00;
    @(negedge clk);
    #0.5;
    if (dw) begin  // R3/R4: beat 0 to word 2A, beat 1 to word 2A+1
      mdl[2*wa]   = mix(mdl[2*wa],   d0, m0);
      mdl[2*wa+1] = mix(mdl[2*wa+1], d1, m1);
    end
  endtask

  task automatic idle();
    step(0, 5, 0, 11, '0, '0, 2'b11, 2'b11);
  endtask

  // output monitor: R2 timing, R8 release
  initial begin : mon
    bit            pv, cv;
    int            pa, ca;
    logic [DW-1:0] e0, e1;
    pv = 0; pa = 0; e0 = '0; e1 = '0;
    forever begin
      @(posedge clk);
      cv = mon_en && rst_n && !rd_sel_n;
      ca = int'(addr);
      #1.25;
      if (mon_en) begin
        if (pv) begin
          e0 = mdl[2*pa];
          e1 = mdl[2*pa+1];
          check(rvalid === 1'b1 && rdata === e0, tag, "R2 first word",
                rdata, rvalid, e0, 1'b1);
        end else
          check(rvalid === 1'b0 && rdata === '0, "R8", "idle high phase",
                rdata, rvalid, '0, 1'b0);
      end
      @(negedge clk);
      #1.25;
      if (mon_en) begin
        if (pv)
          check(rvalid === 1'b1 && rdata === e1, tag, "R2 second word",
                rdata, rvalid, e1, 1'b1);
        else
          check(rvalid === 1'b0 && rdata === '0, "R8", "idle low phase",
                rdata, rvalid, '0, 1'b0);
      end
      pv = cv;
      pa = ca;
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R7 watchdog: cycles=20000 expected completion earlier");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1.25;
    check(rvalid === 1'b0 && rdata === '0, "R1", "in reset", rdata, rvalid, '0, 1'b0);
    rst_n  = 1'b1;
    mon_en = 1'b1;
    @(negedge clk);
    #0.5;
    idle();

    // R4: fill every address, full masks
    tag = "R4";
    for (int a = 0; a < NA; a++)
      step(0, 0, 1, a, pat(a, 0, 1), pat(a, 1, 1), 2'b00, 2'b00);

    // R3: back-to-back read sweep
    tag = "R3";
    for (int a = 0; a < NA; a++) step(1, a, 0, 0, '0, '0, 2'b11, 2'b11);
    idle();

    // R7: read and write every edge, different addresses
    tag = "R7";
    for (int a = 0; a < NA; a++)
      step(1, a, 1, (a + 5) % NA, pat(a, 0, 2), pat(a, 1, 2), 2'b00, 2'b00);
    idle();

    // R5: every per-beat mask pair on every address, read on the next edge
    tag = "R5";
    for (int a = 0; a < NA; a++)
      for (int mc = 0; mc < 16; mc++) begin
        step(0, 0, 1, a, pat(a, mc, 3), pat(a, mc, 4), 2'(mc), 2'(mc >> 2));
        step(1, a, 0, 0, '0, '0, 2'b11, 2'b11);
      end
    idle();

    // R6: read issued on the same edge as a write to that address
    tag = "R6";
    for (int a = 0; a < NA; a++)
      step(1, a, 1, a, pat(a, 7, 5), pat(a, 9, 5), 2'(a), 2'(a >> 1));
    idle();

    // R9: junk during idle cycles, then confirm contents untouched
    tag = "R9";
    for (int k = 0; k < 4; k++) idle();
    for (int a = 0; a < NA; a++) step(1, a, 0, 0, '0, '0, 2'b11, 2'b11);
    for (int k = 0; k < 3; k++) idle();

    done = 1;
    mon_en = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule